// File: doc/BRIEF.md
# Four-Lane Partitioned 12-bit Adder

This block adds two 48-bit words as four separate 12-bit lanes. Each lane gives its own 12-bit sum and its own carry bit. No carry passes from one lane into the next. It is used where several small additions share one wide datapath. Narrow lane inputs are sign- or zero-extended to 12 bits before they reach the block.

The first operand is built by joining a 30-bit upper part and an 18-bit lower part. The second operand arrives whole on a 48-bit port. A 7-bit route code decides how operands reach the adder. Only one code is valid. Any other code forces every output to zero. The block is purely combinational: it holds no registers and no clock reaches it.

Top module: `simd4_add`

## Requirements
- R1: With route code 7'b0110011, result bits [12i+11:12i] equal the low 12 bits of first-operand lane i plus second-operand lane i, for i = 0..3. Lane 0 is bits 11:0 and each higher lane is the next 12-bit field up.
- R2: With the valid route code, carry bit i is bit 12 of the 13-bit sum of lane i. The route code fields are bits [1:0]=11, selecting the joined word; bits [3:2]=00, selecting a zero middle term; and bits [6:4]=011, selecting the 48-bit second input.
- R3: The first operand is formed as {upper part, lower part}. The 30-bit upper part lands on bits 47:18 and the 18-bit lower part on bits 11:0 through 17:0. A lane that straddles bit 18 takes bits from both parts.
- R4: Each lane's carry-in is zero. An overflow in one lane leaves the sum and carry of every other lane unchanged.
- R5: For any route code other than 7'b0110011, all 48 result bits and all 4 carry bits are zero.
- R6: Outputs follow the inputs within the same time step, with no clock edge in between.
- R7: A lane whose operand fields are both zero gives a zero sum and a zero carry, whatever the other lanes hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_hi | input | 30 | Upper part of the first operand (bits 47:18) |
| opa_lo | input | 18 | Lower part of the first operand (bits 17:0) |
| opb | input | 48 | Second operand |
| route | input | 7 | Operand route code; only 7'b0110011 adds |
| sum | output | 48 | Four 12-bit lane sums, lane 0 in bits 11:0 |
| carry | output | 4 | Per-lane carry out, bit i for lane i |

## Verification
The bench uses several kinds of input:
- **All lanes overflow at once.** Every lane holds 0xFFF plus 1. All sums should be zero with all carries set, which shows no carry leaks across a lane boundary.
- **One lane overflows, the rest do not.** Neighbours hold small values, which tells true lane isolation apart from a chain broken in the wrong place.
- **Split operand patterns.** Single-bit patterns sit on either side of bit 18, which separates a correct 30/18 join from a shifted or swapped one.
- **Invalid route codes.** Codes that differ from the valid one in each field show that only the exact code adds.
- **Random words.** These cover general lane arithmetic.

// File: rtl/simd4_add_pkg.sv
package simd4_add_pkg;

    parameter int LANES  = 4;
    parameter int LANE_W = 12;
    parameter int HI_W   = 30;
    parameter int LO_W   = 18;
    parameter int CODE_W = 7;

    localparam int DATA_W = LANES * LANE_W;

    // route code fields: [1:0] first term, [3:2] middle term, [6:4] third term
    localparam logic [1:0] FIRST_JOINED = 2'b11;
    localparam logic [1:0] MID_ZERO     = 2'b00;
    localparam logic [2:0] THIRD_WIDE   = 3'b011;

    typedef struct packed {
        logic              cy;
        logic [LANE_W-1:0] val;
    } lane_res_t;

    typedef struct packed {
        logic [DATA_W-1:0] first;
        logic [DATA_W-1:0] third;
        logic              live;
    } routed_t;

    function automatic lane_res_t lane_sum(input logic [LANE_W-1:0] a,
                                           input logic [LANE_W-1:0] b);
        logic [LANE_W:0] t;
        t = {1'b0, a} + {1'b0, b};
        return lane_res_t'{cy: t[LANE_W], val: t[LANE_W-1:0]};
    endfunction

endpackage

// File: rtl/simd4_route.sv
module simd4_route
    import simd4_add_pkg::*;
(
    input  logic [HI_W-1:0]   opa_hi,
    input  logic [LO_W-1:0]   opa_lo,
    input  logic [DATA_W-1:0] opb,
    input  logic [CODE_W-1:0] route,
    output routed_t           routed
);
    logic code_ok;

    always_comb begin
        code_ok = (route[1:0] == FIRST_JOINED) &&
                  (route[3:2] == MID_ZERO) &&
                  (route[6:4] == THIRD_WIDE);
        routed.live  = code_ok;
        routed.first = code_ok ? {opa_hi, opa_lo} : '0;
        routed.third = code_ok ? opb : '0;
    end

endmodule

// File: rtl/simd4_lane.sv
module simd4_lane
    import simd4_add_pkg::*;
(
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output lane_res_t         res
);
    always_comb res = lane_sum(a, b);

    logic [LANE_W-1:0] back;
    always_comb begin
        back = res.val - a;
        // R1
        lane_diff_chk: assert (back == b)
            else $error("lane sum minus a differs from b");
        // R2
        lane_wrap_chk: assert (res.cy == (res.val < a))
            else $error("lane carry disagrees with wrap");
    end

endmodule

// File: rtl/simd4_add.sv
module simd4_add
    import simd4_add_pkg::*;
(
    input  logic [HI_W-1:0]   opa_hi,
    input  logic [LO_W-1:0]   opa_lo,
    input  logic [DATA_W-1:0] opb,
    input  logic [CODE_W-1:0] route,
    output logic [DATA_W-1:0] sum,
    output logic [LANES-1:0]  carry
);
    routed_t routed;

    simd4_route u_route (
        .opa_hi (opa_hi),
        .opa_lo (opa_lo),
        .opb    (opb),
        .route  (route),
        .routed (routed)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_res_t r;
        simd4_lane u_lane (
            .a   (routed.first[g*LANE_W +: LANE_W]),
            .b   (routed.third[g*LANE_W +: LANE_W]),
            .res (r)
        );
        assign sum[g*LANE_W +: LANE_W] = r.val;
        assign carry[g]                = r.cy;

        always_comb begin
            // R7
            zero_lane_chk: assert (!(routed.first[g*LANE_W +: LANE_W] == '0 &&
                                     routed.third[g*LANE_W +: LANE_W] == '0) ||
                                   (sum[g*LANE_W +: LANE_W] == '0 && !carry[g]))
                else $error("zero lane produced nonzero result");
        end
    end

    always_comb begin
        // R5
        bad_code_sum_chk: assert (routed.live || sum == '0)
            else $error("sum nonzero for invalid route code");
        // R5
        bad_code_cy_chk: assert (routed.live || carry == '0)
            else $error("carry set for invalid route code");
    end

endmodule

// File: tb/simd4_add_tb.sv
module simd4_add_tb;
    import simd4_add_pkg::*;

    localparam logic [CODE_W-1:0] GOOD = 7'b0110011;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [HI_W-1:0]   opa_hi = '0;
    logic [LO_W-1:0]   opa_lo = '0;
    logic [DATA_W-1:0] opb    = '0;
    logic [CODE_W-1:0] route  = '0;
    logic [DATA_W-1:0] sum;
    logic [LANES-1:0]  carry;

    simd4_add u_dut (.opa_hi(opa_hi), .opa_lo(opa_lo), .opb(opb),
                     .route(route), .sum(sum), .carry(carry));

    typedef struct {
        logic [DATA_W-1:0] s;
        logic [LANES-1:0]  c;
        string             req;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int cyc    = 0;

    function automatic exp_t model(input logic [DATA_W-1:0] a,
                                   input logic [DATA_W-1:0] b,
                                   input logic [CODE_W-1:0] code,
                                   input string req);
        exp_t e;
        e.s = '0; e.c = '0; e.req = req;
        if (code == GOOD) begin
            for (int i = 0; i < LANES; i++) begin
                logic [12:0] t;
                t = {1'b0, a[i*12 +: 12]} + {1'b0, b[i*12 +: 12]};
                e.s[i*12 +: 12] = t[11:0];
                e.c[i] = t[12];
            end
        end
        return e;
    endfunction

    task automatic drive(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b,
                         input logic [CODE_W-1:0] code, input string req);
        @(negedge clk);
        opa_hi = a[47:18];
        opa_lo = a[17:0];
        opb    = b;
        route  = code;
        q.push_back(model(a, b, code, req));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // monitor: compares at the rising edge, 2 ns after inputs change
    always @(posedge clk) begin
        if (!rst && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (sum !== e.s) begin
                fails++;
                $display("FAIL %s sum: got %h expected %h", e.req, sum, e.s);
            end
            checks++;
            if (carry !== e.c) begin
                fails++;
                $display("FAIL %s/R2 carry: got %b expected %b", e.req, carry, e.c);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++; fails++;
            $display("FAIL watchdog expired: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [DATA_W-1:0] ra, rb;
        repeat (3) @(posedge clk);
        // reset state: all inputs zero, outputs zero
        checks++;
        if (sum !== '0 || carry !== '0) begin
            fails++;
            $display("FAIL R5 reset: got %h/%b expected 0/0", sum, carry);
        end
        @(negedge clk); rst = 1'b0;

        // R6: same time step response, no clock involved
        opa_hi = 30'h0; opa_lo = 18'h5; opb = 48'h3; route = GOOD;
        #0.5;
        checks++;
        if (sum !== 48'h8) begin
            fails++;
            $display("FAIL R6 settle: got %h expected %h", sum, 48'h8);
        end

        drive(48'h123_456_789_abc, 48'h111_222_333_444, GOOD, "R1");
        // R4 all lanes overflow together
        drive(48'hfff_fff_fff_fff, 48'h001_001_001_001, GOOD, "R4");
        drive(48'hfff_fff_fff_fff, 48'hfff_fff_fff_fff, GOOD, "R4");
        // R4 single lane overflow with small neighbours
        drive(48'h001_800_001_002, 48'h001_800_001_003, GOOD, "R4");
        drive(48'h000_000_fff_000, 48'h000_000_001_000, GOOD, "R4");
        // R3 bits either side of the 30/18 join
        drive(48'h000_000_020_000, 48'h0, GOOD, "R3");
        drive(48'h000_000_040_000, 48'h0, GOOD, "R3");
        drive(48'h800_000_000_000, 48'h0, GOOD, "R3");
        drive(48'h000_000_000_001, 48'h0, GOOD, "R3");
        // R7 unused lanes zero
        drive(48'h000_000_fff_7ff, 48'h000_000_002_801, GOOD, "R7");
        drive(48'h000_abc_000_000, 48'h000_fff_000_000, GOOD, "R7");
        // R5 invalid codes in each field
        drive(48'hfff_fff_fff_fff, 48'h001_001_001_001, 7'b0000000, "R5");
        drive(48'hfff_fff_fff_fff, 48'h001_001_001_001, 7'b0110010, "R5");
        drive(48'hfff_fff_fff_fff, 48'h001_001_001_001, 7'b0110111, "R5");
        drive(48'hfff_fff_fff_fff, 48'h001_001_001_001, 7'b1110011, "R5");
        drive(48'hfff_fff_fff_fff, 48'h001_001_001_001, 7'b0100011, "R5");
        // random lanes
        for (int k = 0; k < 40; k++) begin
            ra = {$urandom(), $urandom()};
            rb = {$urandom(), $urandom()};
            drive(ra, rb, GOOD, "R1");
        end
        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule